// File: doc/BRIEF.md
# Event Interrupt Register Set

This block collects single-cycle event pulses from an IP core into sticky per-event flags and exposes them to firmware over an APB slave port. Each of the `N_FLAGS` events owns one bit position, and that position is the same in all four registers: the raw flags, the enable mask, the masked view and the write-one-to-clear register.

A flag is set by its event pulse and stays set until firmware writes a 1 to its bit in the clear register. The mask chooses which flags may interrupt the processor. A single interrupt line goes high whenever any flag that is set is also enabled. The APB port has no wait states. Read data is driven combinationally during a read transfer.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset is released, the raw flags and the mask are all zero and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[i]` sets raw flag i at the next rising clock edge. The flag stays set until it is cleared. Raw flags read at byte offset 0x0, with flag i in data bit i.
- R3: A write to offset 0x0 (raw flags) has no effect on the flags.
- R4: The mask reads and writes at offset 0x4. Bit i enables flag i, and a 0 disables it. Data bits at or above `N_FLAGS` are not stored and read as 0.
- R5: Offset 0x8 reads the bitwise AND of the raw flags and the mask. A write to offset 0x8 changes neither the flags nor the mask.
- R6: Writing offset 0xC clears every raw flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R7: A read of offset 0xC returns zero, and no bit of the clear register stays set after the write.
- R8: If an event pulse and a clear of the same bit fall in the same cycle, the flag is set after that edge.
- R9: `irq_o` is high exactly when at least one flag is both set and enabled. It follows the register state in the same cycle the state changes.
- R10: A register is written only at the clock edge that ends an APB access phase (`psel_i`, `penable_i` and `pwrite_i` all high). `pready_o` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when high, read when low |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| pready_o | output | 1 | APB ready, always high |
| evt_i | input | N_FLAGS | Event pulses from the IP core, one per flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench drives an event pulse and a clear of the same bit in one access cycle. A design in which the clear has priority would lose that event, and the raw read would come back zero. Writes go to the read-only raw and masked offsets, and a bus phase is left as setup only without an access phase. A decoder that is too loose would then change flags. The bench also writes the mask with ones above `N_FLAGS`, and a wrong register width shows up when the mask is read back. Clearing with mixed ones and zeros exposes a design that treats a 0 as a clear, and the bench follows `irq_o` as the mask and the flags change in turn.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  // Word index taken from paddr[3:2]; the order fixes the offsets 0x0/0x4/0x8/0xC
  typedef enum logic [1:0] {
    REG_RAW  = 2'd0,
    REG_MASK = 2'd1,
    REG_MIS  = 2'd2,
    REG_CLR  = 2'd3
  } reg_idx_e;

  localparam int unsigned WORD_LSB = 2;
  localparam int unsigned IDX_W    = 2;
endpackage

// File: rtl/evt_irq_apb.sv
module evt_irq_apb
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_FLAGS = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  output logic [DATA_W-1:0]  prdata_o,
  output logic               pready_o,
  input  logic [N_FLAGS-1:0] raw_i,
  input  logic [N_FLAGS-1:0] mask_i,
  input  logic [N_FLAGS-1:0] mis_i,
  output logic               wr_mask_o,
  output logic               wr_clr_o,
  output logic [N_FLAGS-1:0] wdata_o
);
  localparam int unsigned IDX_HI = WORD_LSB + IDX_W;

  logic     hit;
  logic     wr_acc;
  logic     rd_sel;
  reg_idx_e idx;
  logic [DATA_W-1:0] rd_d;

  assign idx = reg_idx_e'(paddr_i[IDX_HI-1:WORD_LSB]);

  generate
    if (ADDR_W > IDX_HI) begin : g_hi
      assign hit = (paddr_i[ADDR_W-1:IDX_HI] == '0);
    end else begin : g_nohi
      assign hit = 1'b1;
    end
    if (DATA_W > N_FLAGS) begin : g_wd_unused
      logic unused_wdata;
      assign unused_wdata = ^pwdata_i[DATA_W-1:N_FLAGS];
    end
  endgenerate

  logic unused_addr;
  assign unused_addr = ^paddr_i[WORD_LSB-1:0];

  assign wr_acc    = psel_i & penable_i & pwrite_i & hit;
  assign rd_sel    = psel_i & ~pwrite_i & hit;
  assign wr_mask_o = wr_acc & (idx == REG_MASK);
  assign wr_clr_o  = wr_acc & (idx == REG_CLR);
  assign wdata_o   = pwdata_i[N_FLAGS-1:0];
  assign pready_o  = 1'b1;

  always_comb begin
    rd_d = '0;
    unique case (idx)
      REG_RAW:  rd_d[N_FLAGS-1:0] = raw_i;
      REG_MASK: rd_d[N_FLAGS-1:0] = mask_i;
      REG_MIS:  rd_d[N_FLAGS-1:0] = mis_i;
      REG_CLR:  rd_d = '0;
      default:  rd_d = '0;
    endcase
  end

  assign prdata_o = rd_sel ? rd_d : '0;

  // R7
  clr_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel && idx == REG_CLR) |-> (prdata_o == '0));

  // R10
  no_wr_outside_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |-> !(wr_mask_o || wr_clr_o));
endmodule

// File: rtl/evt_irq_flags.sv
module evt_irq_flags #(
  parameter int unsigned N_FLAGS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FLAGS-1:0] evt_i,
  input  logic               clr_en_i,
  input  logic [N_FLAGS-1:0] clr_data_i,
  output logic [N_FLAGS-1:0] raw_o
);
  logic [N_FLAGS-1:0] raw_q;

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         raw_q[i] <= 1'b0;
      else if (evt_i[i])                   raw_q[i] <= 1'b1; // set beats clear
      else if (clr_en_i && clr_data_i[i])  raw_q[i] <= 1'b0;
    end
  end

  assign raw_o = raw_q;

  // R8
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  // R6
  clr_drops_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((raw_q & $past(clr_data_i) & ~$past(evt_i)) == '0));

  // R2
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  // R10
  flag_idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_en_i && evt_i == '0) |=> $stable(raw_q));
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
  parameter int unsigned N_FLAGS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [N_FLAGS-1:0] wdata_i,
  input  logic [N_FLAGS-1:0] raw_i,
  output logic [N_FLAGS-1:0] mask_o,
  output logic [N_FLAGS-1:0] mis_o,
  output logic               irq_o
);
  logic [N_FLAGS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_en_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
  assign mis_o  = raw_i & mask_q;
  assign irq_o  = |mis_o;

  // R4
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mask_q == $past(wdata_i)));

  // R5
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs #(
  parameter int unsigned N_FLAGS = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  output logic [DATA_W-1:0]  prdata_o,
  output logic               pready_o,
  input  logic [N_FLAGS-1:0] evt_i,
  output logic               irq_o
);
  logic [N_FLAGS-1:0] raw, mask, mis, wdata;
  logic               wr_mask, wr_clr;

  initial begin
    assert (N_FLAGS >= 1 && N_FLAGS <= DATA_W);
    assert (ADDR_W >= 4);
  end

  evt_irq_apb #(.N_FLAGS(N_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_apb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .prdata_o  (prdata_o),
    .pready_o  (pready_o),
    .raw_i     (raw),
    .mask_i    (mask),
    .mis_i     (mis),
    .wr_mask_o (wr_mask),
    .wr_clr_o  (wr_clr),
    .wdata_o   (wdata)
  );

  evt_irq_flags #(.N_FLAGS(N_FLAGS)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .clr_en_i   (wr_clr),
    .clr_data_i (wdata),
    .raw_o      (raw)
  );

  evt_irq_mask #(.N_FLAGS(N_FLAGS)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_mask),
    .wdata_i (wdata),
    .raw_i   (raw),
    .mask_o  (mask),
    .mis_o   (mis),
    .irq_o   (irq_o)
  );

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw != '0));

  // R9
  irq_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask != '0));
endmodule

// File: tb/evt_irq_regs_test.sv
module evt_irq_regs_test;
  localparam int unsigned N  = 8;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [DW-1:0] prdata;
  logic          pready;
  logic [N-1:0]  evt = '0;
  logic          irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } sb_item_t;
  sb_item_t exp_q[$];

  always #4 clk = ~clk;

  evt_irq_regs #(.N_FLAGS(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .pready_o(pready), .evt_i(evt), .irq_o(irq)
  );

  // monitor: compare read data in each read access phase
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expected item, got %h", prdata);
      end else begin
        sb_item_t it;
        it = exp_q.pop_front();
        checks++;
        if (prdata !== it.exp) begin
          errors++;
          $display("FAIL %s: prdata=%h expected=%h", it.tag, prdata, it.exp);
        end
      end
    end
  end

  task automatic apb_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    sb_item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    exp_q.push_back(it);
    @(posedge clk); #1; penable = 1'b1;
    @(posedge clk); #1; psel = 1'b0; penable = 1'b0;
  endtask

  task automatic apb_write_evt(input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input logic [N-1:0] e);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); #1; penable = 1'b1; evt = e;
    @(posedge clk); #1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0; evt = '0;
  endtask

  task automatic apb_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    apb_write_evt(a, d, '0);
  endtask

  task automatic pulse(input logic [N-1:0] e);
    @(posedge clk); #1; evt = e;
    @(posedge clk); #1; evt = '0;
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check_bit(irq, 1'b0, "R1 irq after reset");
    apb_read(4'h0, 32'h0, "R1 raw after reset");
    apb_read(4'h4, 32'h0, "R1 mask after reset");
    apb_read(4'h8, 32'h0, "R1 masked after reset");

    // R2 set and hold
    pulse(8'h05);
    apb_read(4'h0, 32'h05, "R2 raw set by pulse");
    check_bit(irq, 1'b0, "R9 irq low while masked off");
    apb_read(4'h8, 32'h0, "R5 masked zero with mask off");
    repeat (5) @(posedge clk);
    apb_read(4'h0, 32'h05, "R2 raw held");

    // R3 raw is read-only
    apb_write(4'h0, 32'hFF);
    apb_read(4'h0, 32'h05, "R3 raw write ignored");

    // R4 mask width, R5 masked view, R9 irq
    apb_write(4'h4, 32'hFFFF_FF0C);
    apb_read(4'h4, 32'h0C, "R4 mask readback upper zero");
    apb_read(4'h8, 32'h04, "R5 masked = raw & mask");
    check_bit(irq, 1'b1, "R9 irq high with enabled flag");
    apb_write(4'h8, 32'hFF);
    apb_read(4'h8, 32'h04, "R5 masked write ignored");
    apb_read(4'h4, 32'h0C, "R5 mask unchanged by masked write");

    // R6 clear with mixed bits, R7 clear reads zero
    apb_write(4'hC, 32'h01);
    apb_read(4'h0, 32'h04, "R6 clear only one bits");
    check_bit(irq, 1'b1, "R9 irq still high");
    apb_read(4'hC, 32'h0, "R7 clear reads zero");

    // R8 set wins
    apb_write_evt(4'hC, 32'h04, 8'h04);
    apb_read(4'h0, 32'h04, "R8 event beats clear");
    apb_write(4'hC, 32'h04);
    apb_read(4'h0, 32'h00, "R6 clear after collision");
    check_bit(irq, 1'b0, "R9 irq low after clear");

    // R10 setup phase only: no write
    pulse(8'hF0);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = 4'hC; pwdata = 32'hFF; penable = 1'b0;
    @(posedge clk); #1; psel = 1'b0; pwrite = 1'b0;
    apb_read(4'h0, 32'hF0, "R10 setup-only write ignored");
    check_bit(pready, 1'b1, "R10 pready high");
    check_bit(irq, 1'b0, "R9 irq low, flags not enabled");
    apb_write(4'h4, 32'h80);
    check_bit(irq, 1'b1, "R9 irq follows mask");
    apb_read(4'h8, 32'h80, "R5 masked after mask change");

    // R2 accumulation from separate pulses
    pulse(8'h01);
    pulse(8'h02);
    apb_read(4'h0, 32'hF3, "R2 flags accumulate");
    apb_write(4'hC, 32'hFF);
    apb_read(4'h0, 32'h00, "R6 clear all");
    check_bit(irq, 1'b0, "R9 irq low after clear all");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule